// File: doc/BRIEF.md
# Special Register Write Decoder

This block executes the write half of a "move to special register" operation in a small pipelined processor. Each cycle with `valid_i` high carries a 16-bit selector, an extended-write flag and a 32-bit operand. The block checks privilege against the user-mode bit of the visible status register. If the write is allowed, it decodes the selector and loads the operand into the matching special register. Which registers exist depends on the configuration parameters: floating-point support, stack protection, the MMU level, TLB access and the physical address width.

The operation has a latency of one cycle. Besides the register contents, the block drives a privileged-instruction exception pulse together with a cause register. It drives an interrupt-acknowledge code when a status write enables interrupts in low-latency interrupt mode. When a TLB word is written, it drives a one-cycle strobe to the TLB array that carries the current TLB index. The TLB array itself and the exception vectoring belong to the surrounding pipeline.

Top module: `spr_write_unit`

## Requirements
- R1: After reset every special register, the exception cause and all strobes are zero, and `irq_ack_o` is 2'b00.
- R2: A normal write (`ext_i`=0) loads the operand on the next clock edge into the register chosen by the selector: 0x0001 status, 0x0007 FP status, 0x0800 stack low limit, 0x0802 stack high limit, 0x1000 process ID, 0x1001 zone protection, 0x1002 TLB index, 0x1003 TLB low word (lower 32 bits), 0x1004 TLB high word, 0x1005 TLB search.
- R3: When MMU_MODE >= 1 and the visible status has bit 11 (user mode, weight 0x800) set, no register changes. Instead `esr_ec_o` loads 5'b00111 and `exc_o` pulses for one cycle.
- R4: When MMU_MODE = 0, the user-mode bit never blocks a write and never raises an exception.
- R5: A status write becomes visible on `msr_o` one cycle after the write edge. An operation issued in the cycle right after a write that sets user mode is still checked against the old status.
- R6: An extended write (`ext_i`=1) to selector 0x1003 loads operand bits [ADDR_SIZE-33:0] into the TLB low extension and leaves the lower word unchanged.
- R7: An extended write is ignored unless MMU_MODE = 3 and ADDR_SIZE > 32. An extended write with any selector other than 0x1003 is ignored.
- R8: A status write whose operand has bit 1 (interrupt enable, weight 2) set drives `irq_ack_o` to 2'b11 for the following cycle, only when LOW_LAT_IRQ is nonzero. In every other cycle `irq_ack_o` is 2'b00.
- R9: Selectors for registers that cannot be written (for example 0x0000, 0x0003, 0x0005, 0x000B, 0x000D, 0x2000) and unknown selectors change no state and raise no exception.
- R10: FP status is writable only if FPU_LEVEL > 0, and the stack limits only if STACK_PROT != 0. TLB index, low and high need MMU_MODE > 1. Process ID, zone protection and TLB search also need TLB_ACCESS > 1. Otherwise the write is dropped.
- R11: A write to the TLB low or high word pulses `tlb_we_o` for one cycle. The pulse carries `tlb_part_o` (2'b00 low word, 2'b01 low extension, 2'b10 high word), the TLB index held before the write, and the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation valid |
| ext_i | input | 1 | Extended-part write flag |
| sel_i | input | 16 | Special register selector |
| data_i | input | 32 | Source operand |
| exc_o | output | 1 | Privileged-instruction exception pulse |
| esr_ec_o | output | 5 | Exception cause field |
| irq_ack_o | output | 2 | Interrupt acknowledge code |
| tlb_we_o | output | 1 | TLB word write strobe |
| tlb_part_o | output | 2 | Which TLB word is written |
| tlb_idx_o | output | 32 | TLB index for the strobe |
| tlb_wdata_o | output | 32 | TLB write data |
| msr_o | output | 32 | Visible status register |
| fsr_o | output | 32 | FP status register |
| slr_o | output | 32 | Stack low limit |
| shr_o | output | 32 | Stack high limit |
| pid_o | output | 32 | Process ID |
| zpr_o | output | 32 | Zone protection |
| tidx_o | output | 32 | TLB index register |
| tlo_o | output | 32 | TLB low word, lower part |
| tlo_ext_o | output | EXT_W | TLB low word, extension |
| thi_o | output | 32 | TLB high word |
| tsx_o | output | 32 | TLB search register |

## Verification
The hardest case to reach is the shadow cycle after a status write. There, the stored status already holds user mode but the visible status does not, so the privilege check must still pass. The stimulus reaches it with a back-to-back pair: a status write that sets bit 11, followed in the very next cycle by a process-ID write that must land. A third write then has to fault. Three instances with different configurations share the same stimulus, so the gated, ignored and no-MMU cases are compared against a fully featured instance.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam logic [15:0] SEL_MSR  = 16'h0001;
  localparam logic [15:0] SEL_FSR  = 16'h0007;
  localparam logic [15:0] SEL_SLR  = 16'h0800;
  localparam logic [15:0] SEL_SHR  = 16'h0802;
  localparam logic [15:0] SEL_PID  = 16'h1000;
  localparam logic [15:0] SEL_ZPR  = 16'h1001;
  localparam logic [15:0] SEL_TIDX = 16'h1002;
  localparam logic [15:0] SEL_TLO  = 16'h1003;
  localparam logic [15:0] SEL_THI  = 16'h1004;
  localparam logic [15:0] SEL_TSX  = 16'h1005;

  localparam logic [4:0] EC_PRIV = 5'b00111;
  localparam int UM_BIT = 11;
  localparam int IE_BIT = 1;

  typedef enum logic [1:0] {
    TLB_LO     = 2'b00,
    TLB_LO_EXT = 2'b01,
    TLB_HI     = 2'b10
  } tlb_part_e;

  typedef struct packed {
    logic msr;
    logic fsr;
    logic slr;
    logic shr;
    logic pid;
    logic zpr;
    logic tidx;
    logic tlo;
    logic tlo_ext;
    logic thi;
    logic tsx;
  } spr_we_t;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int MMU_MODE   = 3,
  parameter int TLB_ACCESS = 3,
  parameter int FPU_LEVEL  = 1,
  parameter int STACK_PROT = 1,
  parameter int ADDR_SIZE  = 40
) (
  input  logic        valid_i,
  input  logic        ext_i,
  input  logic [15:0] sel_i,
  input  logic        user_i,
  output spr_we_t     we_o,
  output logic        fault_o
);
  localparam bit PRIV_CHK = (MMU_MODE >= 1);
  localparam bit HAS_FSR  = (FPU_LEVEL > 0);
  localparam bit HAS_STK  = (STACK_PROT != 0);
  localparam bit HAS_TLB  = (MMU_MODE > 1);
  localparam bit HAS_TACC = HAS_TLB && (TLB_ACCESS > 1);
  localparam bit HAS_EXT  = (MMU_MODE == 3) && (ADDR_SIZE > 32);

  logic go;

  always_comb begin
    fault_o = valid_i && PRIV_CHK && user_i;
    go      = valid_i && !fault_o;
    we_o    = '0;
    if (go && ext_i) begin
      we_o.tlo_ext = HAS_EXT && (sel_i == SEL_TLO);
    end else if (go) begin
      case (sel_i)
        SEL_MSR:  we_o.msr  = 1'b1;
        SEL_FSR:  we_o.fsr  = HAS_FSR;
        SEL_SLR:  we_o.slr  = HAS_STK;
        SEL_SHR:  we_o.shr  = HAS_STK;
        SEL_PID:  we_o.pid  = HAS_TACC;
        SEL_ZPR:  we_o.zpr  = HAS_TACC;
        SEL_TIDX: we_o.tidx = HAS_TLB;
        SEL_TLO:  we_o.tlo  = HAS_TLB;
        SEL_THI:  we_o.thi  = HAS_TLB;
        SEL_TSX:  we_o.tsx  = HAS_TACC;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/spr_regs.sv
module spr_regs
  import spr_pkg::*;
#(
  parameter int EXT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  spr_we_t          we_i,
  input  logic [31:0]      data_i,
  output logic [31:0]      msr_o,
  output logic [31:0]      fsr_o,
  output logic [31:0]      slr_o,
  output logic [31:0]      shr_o,
  output logic [31:0]      pid_o,
  output logic [31:0]      zpr_o,
  output logic [31:0]      tidx_o,
  output logic [31:0]      tlo_o,
  output logic [EXT_W-1:0] tlo_ext_o,
  output logic [31:0]      thi_o,
  output logic [31:0]      tsx_o
);
  logic [31:0] msr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msr_q     <= '0;
      msr_o     <= '0;
      fsr_o     <= '0;
      slr_o     <= '0;
      shr_o     <= '0;
      pid_o     <= '0;
      zpr_o     <= '0;
      tidx_o    <= '0;
      tlo_o     <= '0;
      tlo_ext_o <= '0;
      thi_o     <= '0;
      tsx_o     <= '0;
    end else begin
      // status takes effect one cycle after it is stored
      msr_o <= msr_q;
      if (we_i.msr)     msr_q     <= data_i;
      if (we_i.fsr)     fsr_o     <= data_i;
      if (we_i.slr)     slr_o     <= data_i;
      if (we_i.shr)     shr_o     <= data_i;
      if (we_i.pid)     pid_o     <= data_i;
      if (we_i.zpr)     zpr_o     <= data_i;
      if (we_i.tidx)    tidx_o    <= data_i;
      if (we_i.tlo)     tlo_o     <= data_i;
      if (we_i.tlo_ext) tlo_ext_o <= data_i[EXT_W-1:0];
      if (we_i.thi)     thi_o     <= data_i;
      if (we_i.tsx)     tsx_o     <= data_i;
    end
  end

  // R2
  we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_i));

  // R6
  ext_keeps_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i.tlo_ext |=> $stable(tlo_o));
endmodule

// File: rtl/spr_write_unit.sv
module spr_write_unit
  import spr_pkg::*;
#(
  parameter int MMU_MODE    = 3,
  parameter int TLB_ACCESS  = 3,
  parameter int FPU_LEVEL   = 1,
  parameter int STACK_PROT  = 1,
  parameter int LOW_LAT_IRQ = 1,
  parameter int ADDR_SIZE   = 40,
  localparam int EXT_W      = (ADDR_SIZE > 32) ? ADDR_SIZE - 32 : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             ext_i,
  input  logic [15:0]      sel_i,
  input  logic [31:0]      data_i,
  output logic             exc_o,
  output logic [4:0]       esr_ec_o,
  output logic [1:0]       irq_ack_o,
  output logic             tlb_we_o,
  output logic [1:0]       tlb_part_o,
  output logic [31:0]      tlb_idx_o,
  output logic [31:0]      tlb_wdata_o,
  output logic [31:0]      msr_o,
  output logic [31:0]      fsr_o,
  output logic [31:0]      slr_o,
  output logic [31:0]      shr_o,
  output logic [31:0]      pid_o,
  output logic [31:0]      zpr_o,
  output logic [31:0]      tidx_o,
  output logic [31:0]      tlo_o,
  output logic [EXT_W-1:0] tlo_ext_o,
  output logic [31:0]      thi_o,
  output logic [31:0]      tsx_o
);
  spr_we_t   we;
  logic      fault;
  logic      tlb_hit;
  tlb_part_e part_d;

  spr_decode #(
    .MMU_MODE  (MMU_MODE),
    .TLB_ACCESS(TLB_ACCESS),
    .FPU_LEVEL (FPU_LEVEL),
    .STACK_PROT(STACK_PROT),
    .ADDR_SIZE (ADDR_SIZE)
  ) i_decode (
    .valid_i(valid_i),
    .ext_i  (ext_i),
    .sel_i  (sel_i),
    .user_i (msr_o[UM_BIT]),
    .we_o   (we),
    .fault_o(fault)
  );

  spr_regs #(.EXT_W(EXT_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .data_i   (data_i),
    .msr_o    (msr_o),
    .fsr_o    (fsr_o),
    .slr_o    (slr_o),
    .shr_o    (shr_o),
    .pid_o    (pid_o),
    .zpr_o    (zpr_o),
    .tidx_o   (tidx_o),
    .tlo_o    (tlo_o),
    .tlo_ext_o(tlo_ext_o),
    .thi_o    (thi_o),
    .tsx_o    (tsx_o)
  );

  assign tlb_hit = we.tlo | we.tlo_ext | we.thi;

  always_comb begin
    if (we.thi)          part_d = TLB_HI;
    else if (we.tlo_ext) part_d = TLB_LO_EXT;
    else                 part_d = TLB_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o       <= 1'b0;
      esr_ec_o    <= '0;
      irq_ack_o   <= 2'b00;
      tlb_we_o    <= 1'b0;
      tlb_part_o  <= 2'b00;
      tlb_idx_o   <= '0;
      tlb_wdata_o <= '0;
    end else begin
      exc_o <= fault;
      if (fault) esr_ec_o <= EC_PRIV;
      irq_ack_o <= (we.msr && data_i[IE_BIT] && (LOW_LAT_IRQ != 0)) ? 2'b11 : 2'b00;
      tlb_we_o <= tlb_hit;
      if (tlb_hit) begin
        tlb_part_o  <= part_d;
        tlb_idx_o   <= tidx_o;
        tlb_wdata_o <= data_i;
      end
    end
  end

  // R8
  ack_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o != 2'b00) |-> (irq_ack_o == 2'b11) && (LOW_LAT_IRQ != 0) &&
      $past(valid_i && !ext_i && (sel_i == SEL_MSR) && data_i[IE_BIT]));

  // R3
  fault_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (esr_ec_o == EC_PRIV) && !tlb_we_o && $stable(pid_o) && $stable(thi_o));

  // R11
  tlb_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_o |-> $past(valid_i && ((sel_i == SEL_TLO) || (sel_i == SEL_THI))) &&
      (tlb_wdata_o == $past(data_i)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pid_o) && $stable(fsr_o) && $stable(thi_o) &&
      $stable(tlo_o) && $stable(tsx_o) && !exc_o && !tlb_we_o);

  // R5
  msr_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(msr_o) |-> $past(valid_i, 2));
endmodule

// File: tb/test_spr_write_unit.sv
module test_spr_write_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic ext = 1'b0;
  logic [15:0] sel = '0;
  logic [31:0] data = '0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // full: all features
  logic a_exc, a_tlb_we; logic [4:0] a_esr; logic [1:0] a_irq, a_part;
  logic [31:0] a_tidx_s, a_twd, a_msr, a_fsr, a_slr, a_shr, a_pid, a_zpr, a_tidx, a_tlo, a_thi, a_tsx;
  logic [7:0] a_ext;
  // mid: MMU 2, no TLB access, no FPU/stack
  logic b_exc, b_tlb_we; logic [4:0] b_esr; logic [1:0] b_irq, b_part;
  logic [31:0] b_tidx_s, b_twd, b_msr, b_fsr, b_slr, b_shr, b_pid, b_zpr, b_tidx, b_tlo, b_thi, b_tsx;
  logic [7:0] b_ext;
  // min: no MMU, no low-latency irq
  logic c_exc, c_tlb_we; logic [4:0] c_esr; logic [1:0] c_irq, c_part;
  logic [31:0] c_tidx_s, c_twd, c_msr, c_fsr, c_slr, c_shr, c_pid, c_zpr, c_tidx, c_tlo, c_thi, c_tsx;
  logic [0:0] c_ext;

  spr_write_unit i_spr_write_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ext_i(ext), .sel_i(sel), .data_i(data),
    .exc_o(a_exc), .esr_ec_o(a_esr), .irq_ack_o(a_irq), .tlb_we_o(a_tlb_we), .tlb_part_o(a_part),
    .tlb_idx_o(a_tidx_s), .tlb_wdata_o(a_twd), .msr_o(a_msr), .fsr_o(a_fsr), .slr_o(a_slr),
    .shr_o(a_shr), .pid_o(a_pid), .zpr_o(a_zpr), .tidx_o(a_tidx), .tlo_o(a_tlo),
    .tlo_ext_o(a_ext), .thi_o(a_thi), .tsx_o(a_tsx));

  spr_write_unit #(.MMU_MODE(2), .TLB_ACCESS(1), .FPU_LEVEL(0), .STACK_PROT(0),
                   .LOW_LAT_IRQ(1), .ADDR_SIZE(40)) i_spr_write_unit_mid (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ext_i(ext), .sel_i(sel), .data_i(data),
    .exc_o(b_exc), .esr_ec_o(b_esr), .irq_ack_o(b_irq), .tlb_we_o(b_tlb_we), .tlb_part_o(b_part),
    .tlb_idx_o(b_tidx_s), .tlb_wdata_o(b_twd), .msr_o(b_msr), .fsr_o(b_fsr), .slr_o(b_slr),
    .shr_o(b_shr), .pid_o(b_pid), .zpr_o(b_zpr), .tidx_o(b_tidx), .tlo_o(b_tlo),
    .tlo_ext_o(b_ext), .thi_o(b_thi), .tsx_o(b_tsx));

  spr_write_unit #(.MMU_MODE(0), .TLB_ACCESS(0), .FPU_LEVEL(0), .STACK_PROT(0),
                   .LOW_LAT_IRQ(0), .ADDR_SIZE(32)) i_spr_write_unit_min (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ext_i(ext), .sel_i(sel), .data_i(data),
    .exc_o(c_exc), .esr_ec_o(c_esr), .irq_ack_o(c_irq), .tlb_we_o(c_tlb_we), .tlb_part_o(c_part),
    .tlb_idx_o(c_tidx_s), .tlb_wdata_o(c_twd), .msr_o(c_msr), .fsr_o(c_fsr), .slr_o(c_slr),
    .shr_o(c_shr), .pid_o(c_pid), .zpr_o(c_zpr), .tidx_o(c_tidx), .tlo_o(c_tlo),
    .tlo_ext_o(c_ext), .thi_o(c_thi), .tsx_o(c_tsx));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    valid = 1'b0; ext = 1'b0; sel = '0; data = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one operation; returns at the negedge after the write edge
  task automatic wr(input logic e, input logic [15:0] s, input logic [31:0] d);
    valid = 1'b1; ext = e; sel = s; data = d;
    @(negedge clk);
    valid = 1'b0; ext = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "msr", a_msr, 0);
    chk("R1", "pid", a_pid, 0);
    chk("R1", "tlo_ext", a_ext, 0);
    chk("R1", "irq_ack", a_irq, 0);
    chk("R1", "esr", a_esr, 0);
    chk("R1", "exc/tlb_we", {a_exc, a_tlb_we}, 0);
  endtask

  task automatic t_map();
    do_reset();
    wr(0, 16'h0001, 32'h0000_0010); @(negedge clk);
    chk("R2", "msr", a_msr, 32'h10);
    wr(0, 16'h0007, 32'h0000_0077); chk("R2", "fsr", a_fsr, 32'h77);
    wr(0, 16'h0800, 32'h0000_1000); chk("R2", "slr", a_slr, 32'h1000);
    wr(0, 16'h0802, 32'h0000_2000); chk("R2", "shr", a_shr, 32'h2000);
    wr(0, 16'h1000, 32'h0000_00AB); chk("R2", "pid", a_pid, 32'hAB);
    wr(0, 16'h1001, 32'h5555_0000); chk("R2", "zpr", a_zpr, 32'h5555_0000);
    wr(0, 16'h1002, 32'h0000_0003); chk("R2", "tidx", a_tidx, 32'h3);
    wr(0, 16'h1003, 32'hDEAD_0000); chk("R2", "tlo", a_tlo, 32'hDEAD_0000);
    wr(0, 16'h1004, 32'hBEEF_0000); chk("R2", "thi", a_thi, 32'hBEEF_0000);
    wr(0, 16'h1005, 32'h0000_0C0C); chk("R2", "tsx", a_tsx, 32'hC0C);
  endtask

  task automatic t_msr_late();
    do_reset();
    wr(0, 16'h0001, 32'h0000_0004);
    chk("R5", "msr not yet visible", a_msr, 0);
    @(negedge clk);
    chk("R5", "msr visible", a_msr, 32'h4);
  endtask

  task automatic t_irq();
    do_reset();
    wr(0, 16'h0001, 32'h0000_0002);
    chk("R8", "ack low-latency", a_irq, 2'b11);
    chk("R8", "ack mid", b_irq, 2'b11);
    chk("R8", "no ack without mode", c_irq, 2'b00);
    @(negedge clk);
    chk("R8", "ack drops", a_irq, 2'b00);
    wr(0, 16'h0001, 32'h0000_0001);
    chk("R8", "no ack without IE", a_irq, 2'b00);
    wr(0, 16'h0007, 32'h0000_0002);
    chk("R8", "no ack other sel", a_irq, 2'b00);
  endtask

  task automatic t_tlb();
    do_reset();
    wr(0, 16'h1002, 32'h0000_0005);
    wr(0, 16'h1003, 32'h0000_AAAA);
    chk("R11", "we lo", a_tlb_we, 1);
    chk("R11", "part lo", a_part, 2'b00);
    chk("R11", "idx", a_tidx_s, 32'h5);
    chk("R11", "wdata", a_twd, 32'hAAAA);
    @(negedge clk);
    chk("R11", "pulse ends", a_tlb_we, 0);
    wr(0, 16'h1004, 32'h1234_5678);
    chk("R11", "part hi", {a_tlb_we, a_part}, 3'b110);
    wr(1, 16'h1003, 32'h0000_01FF);
    chk("R6", "ext field", a_ext, 8'hFF);
    chk("R6", "low word kept", a_tlo, 32'hAAAA);
    chk("R11", "part ext", {a_tlb_we, a_part}, 3'b101);
    chk("R7", "ext ignored mmu2", b_ext, 0);
    chk("R7", "no strobe mmu2", b_tlb_we, 0);
    chk("R7", "mid low kept", b_tlo, 32'hAAAA);
    wr(1, 16'h1004, 32'h0000_0000);
    chk("R7", "ext other sel", a_thi, 32'h1234_5678);
    chk("R7", "ext other sel strobe", a_tlb_we, 0);
  endtask

  task automatic t_gate();
    do_reset();
    wr(0, 16'h0007, 32'h0000_0011);
    chk("R10", "fsr full", a_fsr, 32'h11);
    chk("R10", "fsr no fpu", b_fsr, 0);
    wr(0, 16'h0800, 32'h0000_0022);
    chk("R10", "slr no stack", b_slr, 0);
    wr(0, 16'h1000, 32'h0000_0033);
    chk("R10", "pid no tlb access", b_pid, 0);
    wr(0, 16'h1005, 32'h0000_0044);
    chk("R10", "tsx no tlb access", b_tsx, 0);
    wr(0, 16'h1002, 32'h0000_0055);
    chk("R10", "tidx mmu2", b_tidx, 32'h55);
    chk("R10", "tidx no mmu", c_tidx, 0);
  endtask

  task automatic t_illegal();
    do_reset();
    wr(0, 16'h1000, 32'h0000_0066);
    foreach (sel[i]) ; // no-op keeps loop style local
    wr(0, 16'h0005, 32'hFFFF_FFFF);
    wr(0, 16'h0000, 32'hFFFF_FFFF);
    wr(0, 16'h0003, 32'hFFFF_FFFF);
    wr(0, 16'h000B, 32'hFFFF_FFFF);
    wr(0, 16'h000D, 32'hFFFF_FFFF);
    wr(0, 16'h2000, 32'hFFFF_FFFF);
    chk("R9", "no exception", a_exc, 0);
    chk("R9", "esr untouched", a_esr, 0);
    @(negedge clk);
    chk("R9", "msr untouched", a_msr, 0);
    chk("R9", "pid untouched", a_pid, 32'h66);
    chk("R9", "fsr untouched", a_fsr, 0);
  endtask

  task automatic t_priv();
    do_reset();
    // back to back: UM set, then pid in the shadow cycle
    valid = 1'b1; ext = 1'b0; sel = 16'h0001; data = 32'h0000_0800;
    @(negedge clk);
    sel = 16'h1000; data = 32'h0000_0011;
    @(negedge clk);
    sel = 16'h1000; data = 32'h0000_0022;
    @(negedge clk);
    valid = 1'b0;
    chk("R5", "shadow write landed", a_pid, 32'h11);
    chk("R3", "exc pulse", a_exc, 1);
    chk("R3", "cause", a_esr, 5'b00111);
    chk("R4", "no mmu no exc", c_exc, 0);
    @(negedge clk);
    chk("R3", "exc one cycle", a_exc, 0);
    wr(0, 16'h0001, 32'h0000_0001);
    chk("R3", "exc again", a_exc, 1);
    @(negedge clk);
    chk("R3", "msr blocked", a_msr, 32'h800);
    chk("R4", "msr written no mmu", c_msr, 32'h1);
    chk("R4", "esr no mmu", c_esr, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_map();
    t_msr_late();
    t_irq();
    t_tlb();
    t_gate();
    t_illegal();
    t_priv();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule